// File: doc/BRIEF.md
# Backplane Bus Slave Responder

This block is the slave side of an asynchronous, fully interlocked backplane data bus. It watches the master's address strobe, two data strobes, write line and longword line. It decides whether a cycle is meant for it, and then serves a byte, word or longword read or write against a small bank of 32-bit registers held inside the block. All strobes reach the block through two-flop synchronizers. The address, the modifier and the longword line are taken one clock after the block sees the address strobe go low.

The acknowledge line and the data lines are modelled as a value plus an output enable, so a wrapper at the pad ring can build the open-drain and tri-state drivers. The slave drives acknowledge only after read data is on the bus or write data has been stored. It holds acknowledge for as long as any data strobe stays low. It releases the data lines first and the acknowledge line one clock later, once the address strobe and both data strobes have returned high. A new cycle is never started while acknowledge is still driven.

Byte addresses map onto the bank as follows:
- Address bits `[OFF_W-1:2]` select a register, where `OFF_W = clog2(NUM_REGS)+2`.
- Address bit 1 selects a half. A value of 0 means bits 31:16 and a value of 1 means bits 15:0.
- Within a half, the even byte is the upper eight bits and the odd byte is the lower eight bits.

Top module: `bp_slv_resp`

## Requirements
- R1: After reset, both output enables are low, `ack_no_o` is high, and every register reads as zero.
- R2: A cycle whose address bits `[ADDR_W-1:OFF_W]` differ from `BASE_ADDR`, or whose modifier code has a clear bit in `AM_ACCEPT`, gets no acknowledge, no data drive and no register change.
- R3: The write line sampled with the data strobes sets the direction: high is a read, low is a write.
- R4: With only `ds0_ni` low, the odd byte of the addressed half moves on data bits 7:0. With only `ds1_ni` low, the even byte moves on data bits 15:8. No other register byte is written.
- R5: With both data strobes low and `lword_ni` high, a word moves on data bits 15:0 into or out of the half selected by address bit 1. On a read, bits 31:16 read as zero.
- R6: With both data strobes low and `lword_ni` low, the whole register moves on data bits 31:0.
- R7: On a read, `data_oe_o` is high for at least one clock before `ack_oe_o` rises. On a write, `ack_oe_o` rises only after the register has been updated. `ack_no_o` is low exactly when `ack_oe_o` is high.
- R8: While `ack_oe_o` is high and either data strobe is low, acknowledge stays asserted and the read data stays unchanged.
- R9: The block releases only after the address strobe and both data strobes are high. `data_oe_o` falls 3 clocks after that release, and `ack_oe_o` falls one clock after `data_oe_o`.
- R10: If a master lowers the address strobe again while acknowledge is still driven, the new cycle starts only after acknowledge has been released, and it is then served normally.
- R11: `ack_oe_o` rises on the fourth rising clock edge after the data strobes fall, for reads and writes alike, provided the address phase has already been decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Address strobe, active low, asynchronous |
| ds0_ni | input | 1 | Data strobe for the odd byte lane, active low |
| ds1_ni | input | 1 | Data strobe for the even byte lane, active low |
| write_ni | input | 1 | Direction: high for read, low for write |
| lword_ni | input | 1 | Low selects a 32-bit transfer when both strobes are low |
| addr_i | input | ADDR_W-1 | Byte address, bits ADDR_W-1 down to 1 |
| am_i | input | 6 | Address modifier code |
| data_i | input | 32 | Data lines as seen by the slave |
| data_o | output | 32 | Read data value, zero when not driven |
| data_oe_o | output | 1 | Drive enable for the data lines |
| ack_no_o | output | 1 | Acknowledge value, active low |
| ack_oe_o | output | 1 | Drive enable for the acknowledge line |

## Verification
The bench builds the block with `NUM_REGS=4`, a 24-bit address, a base of `0x00A0C0`, and two accepted modifier codes, `0x39` and `0x3D`. A four-register bank keeps the whole storage visible through longword read-back, so every byte-lane write can be checked against its neighbours. The narrow 16-byte window places a near-miss address one decode bit outside the range. One accepted code and one rejected code let the modifier filter be tested with the address held in range.

// File: rtl/bp_slv_pkg.sv
package bp_slv_pkg;

  typedef enum logic [1:0] {
    XW_ODD,
    XW_EVEN,
    XW_WORD,
    XW_LONG
  } xfer_w_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT_DS,
    ST_READ,
    ST_WRITE,
    ST_ACK,
    ST_REL_DATA,
    ST_SKIP
  } slv_st_e;

  // strobes and longword line are active low
  function automatic xfer_w_e width_of(logic ds0_n, logic ds1_n, logic lword_n);
    if (!ds0_n && !ds1_n) return lword_n ? XW_WORD : XW_LONG;
    else if (!ds0_n)      return XW_ODD;
    else                  return XW_EVEN;
  endfunction

endpackage

// File: rtl/bp_slv_sync.sv
module bp_slv_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bp_slv_decode.sv
module bp_slv_decode #(
  parameter int                HI_W      = 19,
  parameter logic [HI_W-1:0]   BASE_HI   = '0,
  parameter logic [63:0]       AM_ACCEPT = 64'h2200_0000_0000_0000
) (
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic [5:0]      am_i,
  output logic            hit_o
);

  assign hit_o = (addr_hi_i == BASE_HI) && AM_ACCEPT[am_i];

endmodule

// File: rtl/bp_slv_lanes.sv
module bp_slv_lanes
  import bp_slv_pkg::*;
(
  input  xfer_w_e     wid_i,
  input  logic        half_i,
  input  logic [31:0] bus_wdata_i,
  input  logic [31:0] reg_rdata_i,
  output logic [3:0]  be_o,
  output logic [31:0] wdata_al_o,
  output logic [31:0] rdata_bus_o
);

  logic [15:0] half_val;

  assign half_val = half_i ? reg_rdata_i[15:0] : reg_rdata_i[31:16];

  always_comb begin
    wdata_al_o = {2{bus_wdata_i[15:0]}};
    unique case (wid_i)
      XW_ODD: begin
        be_o        = half_i ? 4'b0001 : 4'b0100;
        rdata_bus_o = {24'h0, half_val[7:0]};
      end
      XW_EVEN: begin
        be_o        = half_i ? 4'b0010 : 4'b1000;
        rdata_bus_o = {16'h0, half_val[15:8], 8'h0};
      end
      XW_WORD: begin
        be_o        = half_i ? 4'b0011 : 4'b1100;
        rdata_bus_o = {16'h0, half_val};
      end
      default: begin
        be_o        = 4'b1111;
        wdata_al_o  = bus_wdata_i;
        rdata_bus_o = reg_rdata_i;
      end
    endcase
  end

endmodule

// File: rtl/bp_slv_regbank.sv
module bp_slv_regbank #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);

  logic [31:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < 4; b++)
        if (be_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/bp_slv_resp.sv
module bp_slv_resp
  import bp_slv_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                NUM_REGS  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h00A0C0,
  parameter logic [63:0]       AM_ACCEPT = (64'd1 << 6'h39) | (64'd1 << 6'h3D),
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_ni,
  input  logic              ds0_ni,
  input  logic              ds1_ni,
  input  logic              write_ni,
  input  logic              lword_ni,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [5:0]        am_i,
  input  logic [31:0]       data_i,
  output logic [31:0]       data_o,
  output logic              data_oe_o,
  output logic              ack_no_o,
  output logic              ack_oe_o
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int OFF_W = IDX_W + 2;
  localparam int HI_W  = ADDR_W - OFF_W;

  logic as_s, ds0_s, ds1_s, wr_s;
  logic hit;
  logic ds_any_low, strobes_high;

  slv_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             half_q, lword_q, rd_q;
  xfer_w_e          wid_q, wid_now, lane_wid;
  logic [31:0]      data_q;
  logic [3:0]       be;
  logic [31:0]      wdata_al, rdata_bus, reg_rdata;
  logic             reg_we;

  bp_slv_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b1111)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({as_ni, ds1_ni, ds0_ni, write_ni}),
    .q_o    ({as_s, ds1_s, ds0_s, wr_s})
  );

  bp_slv_decode #(
    .HI_W      (HI_W),
    .BASE_HI   (BASE_ADDR[ADDR_W-1:OFF_W]),
    .AM_ACCEPT (AM_ACCEPT)
  ) u_decode (
    .addr_hi_i (addr_i[ADDR_W-1:OFF_W]),
    .am_i      (am_i),
    .hit_o     (hit)
  );

  assign ds_any_low   = !ds0_s || !ds1_s;
  assign strobes_high = as_s && ds0_s && ds1_s;
  assign wid_now      = width_of(ds0_s, ds1_s, lword_q);
  assign lane_wid     = (st_q == ST_WAIT_DS) ? wid_now : wid_q;

  bp_slv_lanes u_lanes (
    .wid_i       (lane_wid),
    .half_i      (half_q),
    .bus_wdata_i (data_i),
    .reg_rdata_i (reg_rdata),
    .be_o        (be),
    .wdata_al_o  (wdata_al),
    .rdata_bus_o (rdata_bus)
  );

  assign reg_we = (st_q == ST_WRITE);

  bp_slv_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .idx_i   (idx_q),
    .be_i    (be),
    .wdata_i (wdata_al),
    .rdata_o (reg_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
      lword_q <= 1'b1;
      rd_q    <= 1'b0;
      wid_q   <= XW_LONG;
      data_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:    if (!as_s) st_q <= ST_DECODE;
        ST_DECODE: begin
          idx_q   <= addr_i[OFF_W-1:2];
          half_q  <= addr_i[1];
          lword_q <= lword_ni;
          st_q    <= hit ? ST_WAIT_DS : ST_SKIP;
        end
        ST_WAIT_DS: begin
          if (as_s) st_q <= ST_IDLE;
          else if (ds_any_low) begin
            wid_q <= wid_now;
            rd_q  <= wr_s;
            if (wr_s) begin
              data_q <= rdata_bus;
              st_q   <= ST_READ;
            end else begin
              st_q   <= ST_WRITE;
            end
          end
        end
        ST_READ:     st_q <= ST_ACK;
        ST_WRITE:    st_q <= ST_ACK;
        ST_ACK:      if (strobes_high) st_q <= ST_REL_DATA;
        ST_REL_DATA: st_q <= ST_IDLE;
        ST_SKIP:     if (as_s) st_q <= ST_IDLE;
        default:     st_q <= ST_IDLE;
      endcase
    end
  end

  assign data_oe_o = rd_q && ((st_q == ST_READ) || (st_q == ST_ACK));
  assign data_o    = data_oe_o ? data_q : '0;
  assign ack_oe_o  = (st_q == ST_ACK) || (st_q == ST_REL_DATA);
  assign ack_no_o  = !ack_oe_o;

  AST_ACK_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_oe_o) && rd_q |-> $past(data_oe_o)); // R7
  AST_ACK_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_oe_o) && !rd_q |-> $past(reg_we)); // R7
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_o && ds_any_low |=> ack_oe_o); // R8
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o && $past(data_oe_o) |-> $stable(data_o)); // R8
  AST_RELEASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_oe_o) |-> !$past(data_oe_o)); // R9
  AST_NO_EARLY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_o |=> st_q != ST_DECODE); // R10

endmodule

// File: tb/bp_slv_resp_tb.sv
module bp_slv_resp_tb;

  localparam logic [23:0] BASE = 24'h00A0C0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, wr_n = 1'b1, lw_n = 1'b1;
  logic [23:1] addr = '0;
  logic [5:0]  am = '0;
  logic [31:0] wdata = '0;
  logic [31:0] data_o;
  logic        data_oe, ack_n, ack_oe;

  int n_chk = 0, n_err = 0, cyc = 0, ack_low_cnt = 0;
  logic [7:0]  mem_m [4][4];
  bit          mon_on = 1'b0;
  logic [31:0] mon_exp = '0;

  always #4 clk = ~clk;

  bp_slv_resp #(
    .ADDR_W(24), .NUM_REGS(4), .BASE_ADDR(BASE),
    .AM_ACCEPT((64'd1 << 6'h39) | (64'd1 << 6'h3D))
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .as_ni(as_n), .ds0_ni(ds0_n), .ds1_ni(ds1_n),
    .write_ni(wr_n), .lword_ni(lw_n), .addr_i(addr), .am_i(am), .data_i(wdata),
    .data_o(data_o), .data_oe_o(data_oe), .ack_no_o(ack_n), .ack_oe_o(ack_oe)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(ack_n == !ack_oe, "R7 ack value", {31'h0, ack_n}, {31'h0, !ack_oe});
      if (!ack_oe) ack_low_cnt++;
      if (mon_on && ack_oe && data_oe)
        check(data_o == mon_exp, "R8 read data", data_o, mon_exp);
    end
    if (cyc > 100000) begin
      check(1'b0, "watchdog", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] model_read(logic [23:0] a, logic d0, logic d1, logic lw);
    int i = int'(a[3:2]);
    int hb = a[1] ? 1 : 3;
    int lb = a[1] ? 0 : 2;
    if (!d0 && !d1 && !lw) return {mem_m[i][3], mem_m[i][2], mem_m[i][1], mem_m[i][0]};
    if (!d0 && !d1)        return {16'h0, mem_m[i][hb], mem_m[i][lb]};
    if (!d0)               return {24'h0, mem_m[i][lb]};
    return {16'h0, mem_m[i][hb], 8'h0};
  endfunction

  task automatic model_write(logic [23:0] a, logic d0, logic d1, logic lw, logic [31:0] d);
    int i = int'(a[3:2]);
    int hb = a[1] ? 1 : 3;
    int lb = a[1] ? 0 : 2;
    if (!d0 && !d1 && !lw) begin
      for (int b = 0; b < 4; b++) mem_m[i][b] = d[8*b +: 8];
    end else begin
      if (!d0) mem_m[i][lb] = d[7:0];
      if (!d1) mem_m[i][hb] = d[15:8];
    end
  endtask

  task automatic bus_cycle(input logic [23:0] a, input logic [5:0] m, input bit rd,
                           input logic lw, input logic d0, input logic d1,
                           input logic [31:0] wd, input bit exp_hit, input int hold,
                           input bit quick, input string rq, output logic [31:0] got);
    int lat, t, td, ta;
    bit seen;
    logic [31:0] exp;
    got = '0;
    exp = model_read(a, d0, d1, lw);
    @(negedge clk);
    addr = a[23:1]; am = m; lw_n = lw; wr_n = rd; as_n = 1'b0;
    repeat (3) @(negedge clk);
    wdata = wd; ds0_n = d0; ds1_n = d1;
    if (exp_hit) begin
      lat = 0;
      while (!ack_oe && lat < 20) begin @(negedge clk); lat++; end
      check(ack_oe, {rq, " ack"}, {31'h0, ack_oe}, 1);
      check(lat == 4, "R11 latency", lat, 4);
      if (rd) begin
        got = data_o;
        check(data_oe && data_o == exp, rq, data_o, exp);
        mon_exp = exp; mon_on = 1'b1;
      end
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(ack_oe && (!rd || data_o == exp), "R8 hold", data_o, exp);
      end
      as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1;
      if (quick) begin
        @(negedge clk);
      end else begin
        td = -1; ta = -1;
        for (t = 1; t <= 8; t++) begin
          @(negedge clk);
          if (td < 0 && !data_oe) td = t;
          if (ta < 0 && !ack_oe) ta = t;
        end
        if (rd) begin
          check(td == 3, "R9 data release", td, 3);
          check(ta == td + 1, "R9 ack after data", ta, td + 1);
        end else begin
          check(ta == 4, "R9 ack release", ta, 4);
        end
      end
      mon_on = 1'b0;
      if (!rd) model_write(a, d0, d1, lw, wd);
    end else begin
      seen = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (ack_oe || data_oe) seen = 1'b1;
      end
      check(!seen, {rq, " no response"}, {31'h0, seen}, 0);
      as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] r;
    int gap;
    for (int i = 0; i < 4; i++) for (int b = 0; b < 4; b++) mem_m[i][b] = 8'h0;
    repeat (3) @(negedge clk);
    check(!ack_oe && !data_oe && ack_n, "R1 reset outputs", {29'h0, ack_oe, data_oe, ack_n}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    bus_cycle(BASE + 0, 6'h39, 1, 0, 0, 0, 0, 1, 0, 0, "R1 reset contents", r);
    // R6 longword write and read back
    bus_cycle(BASE + 4, 6'h39, 0, 0, 0, 0, 32'hDEADBEEF, 1, 0, 0, "R6 long write", r);
    bus_cycle(BASE + 4, 6'h3D, 1, 0, 0, 0, 0, 1, 0, 0, "R6 long read", r);
    // R5 words into both halves
    bus_cycle(BASE + 8,  6'h39, 0, 1, 0, 0, 32'hFFFF1234, 1, 0, 0, "R5 word write hi", r);
    bus_cycle(BASE + 10, 6'h39, 0, 1, 0, 0, 32'h00005678, 1, 0, 0, "R5 word write lo", r);
    bus_cycle(BASE + 8,  6'h39, 1, 0, 0, 0, 0, 1, 0, 0, "R5 long view of words", r);
    check(r == 32'h12345678, "R5 assembled", r, 32'h12345678);
    bus_cycle(BASE + 10, 6'h39, 1, 1, 0, 0, 0, 1, 0, 0, "R5 word read lo", r);
    // R4 byte lanes, R3 direction
    bus_cycle(BASE + 12, 6'h39, 0, 1, 0, 1, 32'h000077AB, 1, 0, 0, "R4 odd byte write", r);
    bus_cycle(BASE + 12, 6'h39, 0, 1, 1, 0, 32'h0000CD99, 1, 0, 0, "R4 even byte write", r);
    bus_cycle(BASE + 14, 6'h39, 0, 1, 0, 1, 32'h00000011, 1, 0, 0, "R4 odd byte write lo", r);
    bus_cycle(BASE + 12, 6'h39, 1, 0, 0, 0, 0, 1, 0, 0, "R4 long view of bytes", r);
    check(r == 32'hCDAB0011, "R4 assembled", r, 32'hCDAB0011);
    bus_cycle(BASE + 14, 6'h39, 1, 1, 1, 0, 0, 1, 0, 0, "R4 even byte read", r);
    bus_cycle(BASE + 12, 6'h39, 1, 1, 0, 1, 0, 1, 0, 0, "R3 odd byte read", r);
    check(r == 32'h000000AB, "R3 read direction", r, 32'hAB);
    // R2 mismatches
    bus_cycle(BASE + 24'h20, 6'h39, 0, 0, 0, 0, 32'hBAD0BAD0, 0, 0, 0, "R2 address miss", r);
    bus_cycle(BASE + 4, 6'h3E, 0, 0, 0, 0, 32'hBAD1BAD1, 0, 0, 0, "R2 modifier miss", r);
    bus_cycle(BASE + 0, 6'h39, 1, 0, 0, 0, 0, 1, 0, 0, "R2 reg0 untouched", r);
    bus_cycle(BASE + 4, 6'h39, 1, 0, 0, 0, 0, 1, 0, 0, "R2 reg1 untouched", r);
    check(r == 32'hDEADBEEF, "R2 reg1 value", r, 32'hDEADBEEF);
    // R8 long hold
    bus_cycle(BASE + 8, 6'h39, 1, 0, 0, 0, 0, 1, 10, 0, "R8 held read", r);
    // R10 address strobe falls again before ack release
    bus_cycle(BASE + 4, 6'h39, 1, 0, 0, 0, 0, 1, 0, 1, "R10 first", r);
    gap = ack_low_cnt;
    bus_cycle(BASE + 10, 6'h3D, 1, 1, 0, 0, 0, 1, 0, 0, "R10 second", r);
    check(ack_low_cnt > gap, "R10 ack released between", ack_low_cnt, gap + 1);
    check(r == 32'h00005678, "R10 second data", r, 32'h5678);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule